// File: doc/BRIEF.md
# Lane-Masked Simple Dual-Port RAM

This block is a synthesizable behavioural model of a two-clock block RAM with one port that only writes and one that only reads. The write side always carries an 18-bit word built from two 9-bit lanes. A separate enable for each lane lets a caller update one half of a word and leave the other half alone. The read side is built at elaboration time either 18 bits wide or 9 bits wide. In both cases it returns data through an output register that holds zero at start-up and can be cleared by a reset input.

Both ports use 13-bit byte-style addresses. The storage holds 512 words of 18 bits. Address bits below the granularity of the access are ignored. The reset acts on the read output register only. A parameter picks whether that reset is sampled on the read clock or acts at once. The whole content is preloaded from a fully defined parameter, so no location ever reads as unknown.

Top module: `lane_sdp_ram`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_ce` high, each lane whose bit in `wr_lane_en` is set stores its half of `wr_data` into word `wr_addr[12:4]`. Bit 0 selects `wr_data[8:0]` and bit 1 selects `wr_data[17:9]`. A lane whose bit is clear keeps its contents.
- R2: While `wr_ce` is low, no location changes, whatever the lane enables are.
- R3: A write cycle with both lane enables low leaves the memory unchanged.
- R4: With `RD_W`=18 and `rd_ce` high, the rising `rd_clk` edge loads the output register with word `rd_addr[12:4]`. Address bits [3:0] have no effect.
- R5: With `RD_W`=9, `rd_addr[12:4]` picks the word and `rd_addr[3]` picks the lane: 0 gives bits [8:0] and 1 gives bits [17:9]. That lane is placed in the upper half of the internal 18-bit output word, and `rd_data` is that upper half. Bits [2:0] have no effect.
- R6: While `rd_ce` is low and no reset is applied, `rd_data` holds its value.
- R7: With `RST_MODE`=RST_SYNC, `rd_rst` high at a rising `rd_clk` edge clears `rd_data` to zero, even if `rd_ce` is low. The memory contents are not affected.
- R8: With `RST_MODE`=RST_ASYNC, `rd_data` becomes zero as soon as `rd_rst` rises, without waiting for a clock edge, and stays zero while `rd_rst` is high.
- R9: Before any clock edge, `rd_data` is zero. Word i of the memory starts as `INIT[i*18 +: 18]`.
- R10: When one rising edge both writes a word and reads that same word, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock, rising edge |
| wr_ce | input | 1 | Write port clock enable |
| wr_lane_en | input | 2 | Per-lane write enables (bit 0 low lane, bit 1 high lane) |
| wr_addr | input | 13 | Write address; bits [12:4] pick the word |
| wr_data | input | 18 | Write data, two 9-bit lanes |
| rd_clk | input | 1 | Read port clock, rising edge |
| rd_ce | input | 1 | Read port clock enable |
| rd_rst | input | 1 | Read output register clear, active high |
| rd_addr | input | 13 | Read address |
| rd_data | output | RD_W | Registered read data |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a write and a read to the same word. The bench ties both clocks to one source and steers both addresses into a 32-word window, both in a directed case and over thousands of random cycles. Each such read must return the pre-write value held by a behavioural memory model. The second pair is a reset and a load enable on the read side. Here the bench raises `rd_rst` together with `rd_ce`, and also raises it part-way through a cycle. The synchronous instance must keep its value until the edge, while the asynchronous instance must read zero at once.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int LANE_W     = 9;
    localparam int LANES      = 2;
    localparam int WORD_W     = LANE_W * LANES;
    localparam int WORD_SHIFT = 4;   // byte-style address bits under one 18-bit word
    localparam int LANE_BIT   = 3;   // address bit that picks a lane for 9-bit reads

    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        lane_t hi;
        lane_t lo;
    } word_t;

    typedef enum logic {
        RST_SYNC  = 1'b0,
        RST_ASYNC = 1'b1
    } rst_mode_e;

    function automatic lane_t pick_lane(input word_t w, input logic sel);
        return sel ? w.hi : w.lo;
    endfunction

endpackage

// File: rtl/sdp_store.sv
module sdp_store
    import sdp_pkg::*;
#(
    parameter int WIDX_W = 9,
    parameter int DEPTH  = 1 << WIDX_W,
    parameter logic [DEPTH*WORD_W-1:0] INIT = '0
) (
    input  logic              wclk,
    input  logic              wce,
    input  logic [LANES-1:0]  wen,
    input  logic [WIDX_W-1:0] widx,
    input  word_t             wdata,
    input  logic [WIDX_W-1:0] ridx,
    output word_t             rword
);

    logic [WORD_W-1:0] rbits;
    assign rword = word_t'(rbits);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_t mem [DEPTH];

        initial begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] = INIT[i*WORD_W + k*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge wclk) begin
            if (wce && wen[k]) begin
                mem[widx] <= wdata[k*LANE_W +: LANE_W];
            end
        end

        assign rbits[k*LANE_W +: LANE_W] = mem[ridx];

        // Checker: the lane addressed last edge holds either the new data or its old value.
        logic              chk_on = 1'b0;
        logic [WIDX_W-1:0] chk_idx;
        lane_t             chk_val;

        always_ff @(posedge wclk) begin
            chk_on  <= 1'b1;
            chk_idx <= widx;
            chk_val <= (wce && wen[k]) ? wdata[k*LANE_W +: LANE_W] : mem[widx];
        end

        AST_LANE_RESULT: assert property (@(posedge wclk) disable iff (!chk_on)
            mem[chk_idx] == chk_val); // R1 R2 R3
    end

endmodule

// File: rtl/sdp_rdreg.sv
module sdp_rdreg
    import sdp_pkg::*;
#(
    parameter int        RD_W     = 18,
    parameter rst_mode_e RST_MODE = RST_SYNC
) (
    input  logic            rclk,
    input  logic            rce,
    input  logic            rrst,
    input  word_t           rword,
    input  logic            lane_sel,
    output logic [RD_W-1:0] dout
);

    word_t q = '0;
    word_t nxt;

    if (RD_W == WORD_W) begin : g_wide
        logic unused_sel;
        assign unused_sel = lane_sel;
        assign nxt  = rword;
        assign dout = q;
        logic unused_lo;
        assign unused_lo = 1'b0;
    end else begin : g_narrow
        assign nxt  = {pick_lane(rword, lane_sel), lane_t'(0)};
        assign dout = q.hi;
        logic unused_lo;
        assign unused_lo = ^q.lo;
    end

    if (RST_MODE == RST_ASYNC) begin : g_async
        always_ff @(posedge rclk or posedge rrst) begin
            if (rrst) begin
                q <= '0;
            end else if (rce) begin
                q <= nxt;
            end
        end

        always @(negedge rclk) begin
            if (rrst) begin
                AST_ASYNC_CLEAR: assert (q == '0); // R8
            end
        end
    end else begin : g_sync
        always_ff @(posedge rclk) begin
            if (rrst) begin
                q <= '0;
            end else if (rce) begin
                q <= nxt;
            end
        end
    end

    logic rst_seen = 1'b0;
    always_ff @(posedge rclk) begin
        rst_seen <= rrst;
    end

    always @(negedge rclk) begin
        if (rst_seen) begin
            AST_RST_CLEAR: assert (q == '0); // R7
        end
    end

    AST_HOLD_NO_CE: assert property (@(posedge rclk) disable iff (rrst)
        !rce |=> $stable(q)); // R6

    AST_LOAD_ON_CE: assert property (@(posedge rclk) disable iff (rrst)
        rce |=> q == $past(nxt)); // R4 R5

endmodule

// File: rtl/lane_sdp_ram.sv
module lane_sdp_ram
    import sdp_pkg::*;
#(
    parameter int        ADDR_W   = 13,
    parameter int        RD_W     = 18,
    parameter rst_mode_e RST_MODE = RST_SYNC,
    parameter logic [(1 << (ADDR_W - WORD_SHIFT))*WORD_W-1:0] INIT = '0
) (
    input  logic              wr_clk,
    input  logic              wr_ce,
    input  logic [LANES-1:0]  wr_lane_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_ce,
    input  logic              rd_rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data
);

    localparam int WIDX_W = ADDR_W - WORD_SHIFT;
    localparam int DEPTH  = 1 << WIDX_W;

    word_t rword;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{wr_addr[WORD_SHIFT-1:0], rd_addr[LANE_BIT-1:0]};

    sdp_store #(
        .WIDX_W (WIDX_W),
        .DEPTH  (DEPTH),
        .INIT   (INIT)
    ) u_store (
        .wclk  (wr_clk),
        .wce   (wr_ce),
        .wen   (wr_lane_en),
        .widx  (wr_addr[ADDR_W-1:WORD_SHIFT]),
        .wdata (word_t'(wr_data)),
        .ridx  (rd_addr[ADDR_W-1:WORD_SHIFT]),
        .rword (rword)
    );

    sdp_rdreg #(
        .RD_W     (RD_W),
        .RST_MODE (RST_MODE)
    ) u_rdreg (
        .rclk     (rd_clk),
        .rce      (rd_ce),
        .rrst     (rd_rst),
        .rword    (rword),
        .lane_sel (rd_addr[LANE_BIT]),
        .dout     (rd_data)
    );

endmodule

// File: tb/lane_sdp_ram_tb.sv
module lane_sdp_ram_tb;

    localparam int NWORDS = 512;

    function automatic logic [17:0] init_word(input int i);
        return 18'((i * 37 + 5) ^ (i << 9) ^ 18'h2A5A5);
    endfunction

    function automatic logic [NWORDS*18-1:0] mk_init();
        logic [NWORDS*18-1:0] r;
        for (int i = 0; i < NWORDS; i++) r[i*18 +: 18] = init_word(i);
        return r;
    endfunction

    localparam logic [NWORDS*18-1:0] INIT_V = mk_init();

    logic        clk = 1'b0;
    logic        wr_ce = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [12:0] wr_addr = '0;
    logic [17:0] wr_data = '0;
    logic        rd_ce = 1'b0;
    logic        rd_rst = 1'b0;
    logic [12:0] rd_addr = '0;
    logic [17:0] dout_w;
    logic [8:0]  dout_n;

    always #4 clk = ~clk;  // 125 MHz

    lane_sdp_ram #(.RD_W(18), .RST_MODE(sdp_pkg::RST_SYNC), .INIT(INIT_V)) u_dut (
        .wr_clk(clk), .wr_ce(wr_ce), .wr_lane_en(wr_be), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_clk(clk), .rd_ce(rd_ce), .rd_rst(rd_rst), .rd_addr(rd_addr), .rd_data(dout_w));

    lane_sdp_ram #(.RD_W(9), .RST_MODE(sdp_pkg::RST_ASYNC), .INIT(INIT_V)) u_dut_n (
        .wr_clk(clk), .wr_ce(wr_ce), .wr_lane_en(wr_be), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_clk(clk), .rd_ce(rd_ce), .rd_rst(rd_rst), .rd_addr(rd_addr), .rd_data(dout_n));

    int total = 0;
    int bad = 0;
    string phase = "R9";
    logic [17:0] model [NWORDS];
    logic [17:0] exp_w = '0;
    logic [8:0]  exp_n = '0;

    task automatic chk(input string tag, input string what, input logic [17:0] got, input logic [17:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Reference model: old data is read before the write lands (R10).
    always @(posedge clk) begin
        logic [17:0] w;
        w = model[rd_addr[12:4]];
        if (rd_rst) begin
            exp_w = '0;
            exp_n = '0;
        end else if (rd_ce) begin
            exp_w = w;
            exp_n = rd_addr[3] ? w[17:9] : w[8:0];
        end
        if (wr_ce) begin
            if (wr_be[0]) model[wr_addr[12:4]][8:0]  = wr_data[8:0];
            if (wr_be[1]) model[wr_addr[12:4]][17:9] = wr_data[17:9];
        end
    end

    always @(posedge clk) begin
        #1;
        chk(phase, "wide", dout_w, exp_w);
        chk(phase, "narrow", {9'd0, dout_n}, {9'd0, (rd_rst ? 9'd0 : exp_n)});
    end

    task automatic step(input logic we, input logic [1:0] be, input int wword, input logic [3:0] wlow,
                        input logic [17:0] wd, input logic re, input int rword, input logic [3:0] rlow,
                        input logic rst);
        @(posedge clk);
        #2;
        wr_ce   = we;
        wr_be   = be;
        wr_addr = {wword[8:0], wlow};
        wr_data = wd;
        rd_ce   = re;
        rd_addr = {rword[8:0], rlow};
        rd_rst  = rst;
    endtask

    task automatic rd(input int word, input logic [3:0] low);
        step(1'b0, 2'b00, 0, 4'h0, 18'h0, 1'b1, word, low, 1'b0);
    endtask

    initial begin
        #(8 * 60000);
        bad++;
        $display("FAIL watchdog expired in phase %s", phase);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NWORDS; i++) model[i] = init_word(i);
        #1;
        chk("R9", "wide at start", dout_w, 18'h0);
        chk("R9", "narrow at start", {9'd0, dout_n}, 18'h0);

        // R7: sync clear with enable high
        phase = "R7";
        for (int i = 0; i < 3; i++) step(1'b0, 2'b00, 0, 4'h0, 0, 1'b1, i + 1, 4'h8, 1'b1);

        // R4/R5/R9: preload read-back, low address bits varied
        phase = "R4/R5/R9";
        for (int i = 0; i < 24; i++) rd(i, 4'(i * 5));
        rd(NWORDS - 1, 4'hF);
        rd(NWORDS - 1, 4'h7);

        // R1: lane writes
        phase = "R1";
        step(1'b1, 2'b11, 5, 4'h3, 18'h3_1234, 1'b0, 0, 0, 1'b0);
        step(1'b1, 2'b01, 6, 4'h0, 18'h2_AB55, 1'b0, 0, 0, 1'b0);
        step(1'b1, 2'b10, 7, 4'hC, 18'h1_F00F, 1'b0, 0, 0, 1'b0);
        for (int i = 5; i < 8; i++) begin rd(i, 4'h0); rd(i, 4'h8); end

        // R2: clock enable low blocks writes
        phase = "R2";
        step(1'b0, 2'b11, 5, 4'h0, 18'h0_0001, 1'b0, 0, 0, 1'b0);
        rd(5, 4'h0); rd(5, 4'h8);

        // R3: no lane enabled
        phase = "R3";
        step(1'b1, 2'b00, 6, 4'h0, 18'h3_FFFF, 1'b0, 0, 0, 1'b0);
        rd(6, 4'h0); rd(6, 4'h9);

        // R6: enable low while address moves
        phase = "R6";
        rd(7, 4'h8);
        for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 0, 0, 0, 1'b0, 100 + i, 4'(i * 4), 1'b0);

        // R10: same-edge write and read of one word
        phase = "R10";
        step(1'b1, 2'b11, 9, 4'h0, 18'h2_5A5A, 1'b1, 9, 4'h8, 1'b0);
        rd(9, 4'h8);
        rd(9, 4'h0);

        // R7: clear with read enable low, memory intact afterwards
        phase = "R7";
        rd(5, 4'h8);
        step(1'b0, 2'b00, 0, 0, 0, 1'b0, 5, 4'h8, 1'b1);
        step(1'b0, 2'b00, 0, 0, 0, 1'b0, 5, 4'h8, 1'b0);
        rd(5, 4'h8);
        rd(5, 4'h0);

        // R8: mid-cycle clear, async instance drops at once, sync one waits
        phase = "R8";
        rd(7, 4'h8);
        rd(7, 4'h8);
        @(posedge clk);
        #3;
        rd_ce  = 1'b0;
        rd_rst = 1'b1;
        #1;
        chk("R8", "narrow immediate clear", {9'd0, dout_n}, 18'h0);
        chk("R8", "wide holds before edge", dout_w, exp_w);
        step(1'b0, 2'b00, 0, 0, 0, 1'b1, 7, 4'h8, 1'b0);
        rd(7, 4'h8);

        // R4/R10 mixed random traffic over a small window to force collisions
        phase = "R4/R10 random";
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, 2'($urandom), $urandom % 32, 4'($urandom), 18'($urandom),
                 ($urandom % 5) != 0, $urandom % 32, 4'($urandom), ($urandom % 40) == 0);
        end
        step(1'b0, 2'b00, 0, 0, 0, 1'b0, 0, 0, 1'b0);
        @(posedge clk);
        #3;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule